// File: doc/BRIEF.md
# Pairwise Stream Block Adder

This block takes a serial stream of unsigned samples and adds them in fixed, non-overlapping pairs. A strobe marks each sample it takes in. The accepted samples are counted from 1. The first sample of each pair is held in a register. When the second sample arrives, the two are added and the sum is sent out, together with a one-cycle valid flag. The windows do not slide: sample 2n-1 and sample 2n form one pair, and no sample belongs to two pairs.

Both the result and the valid flag come from registers, so a sum appears in the clock cycle after the edge that takes in the second sample of its pair. The sum has the same width as the samples and wraps on overflow. The data output always holds a defined value. After reset it is zero. After that it keeps the most recent pair sum until the next pair completes. A synchronous reset discards any half-finished pair.

Top module: `pair_block_adder`

## Requirements
- R1: While reset is high at a clock edge, and in the cycle after it, `sum_valid` is 0 and `sum_data` is 0.
- R2: When the second accepted sample of a pair is taken in at an edge, `sum_valid` is 1 after that edge and `sum_data` equals the first sample plus the second sample of that pair.
- R3: After the edge that takes in the first sample of a pair (accepted samples 1, 3, 5, … counted from reset), `sum_valid` is 0.
- R4: `sum_valid` is high for exactly one cycle per completed pair. It is never high in two consecutive cycles.
- R5: Cycles with `smp_req` low do not advance the pairing. A gap of any length between the two samples of a pair still gives their sum.
- R6: The sum is taken modulo 2^DATA_W. With DATA_W = 8, 255 + 255 gives 254 and 200 + 100 gives 44.
- R7: `sum_data` never carries an unknown value. While `sum_valid` is 0 it keeps the last pair sum, or 0 if no pair has completed since reset.
- R8: A reset between the two samples of a pair drops the stored first sample. The first sample accepted after reset starts a new pair.
- R9: `smp_data` is ignored in cycles where `smp_req` is low. It neither joins a sum nor changes `sum_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_req | input | 1 | Qualifies `smp_data` as an accepted sample at this edge |
| smp_data | input | DATA_W (8) | Unsigned input sample |
| sum_valid | output | 1 | High for one cycle when `sum_data` holds a fresh pair sum |
| sum_data | output | DATA_W (8) | Wrapped sum of the latest completed pair |

## Verification
The bench targets the following corner cases and the fault each one exposes:
- Odd positions: a design that sums overlapping windows would raise the valid flag at odd positions.
- Idle cycles inside a pair: a design whose phase toggles every cycle would pair the wrong samples, or add in the data present during idle cycles.
- Overflow (255 + 255, 200 + 100): a design with the wrong carry handling would return a saturated or truncated wrong value.
- Reset between the two halves of a pair: a design that keeps its phase through reset would pair the first new sample with a stale operand and shift every later sum by one position.

// File: rtl/pair_add_pkg.sv
package pair_add_pkg;

  localparam int PA_DATA_W = 8;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } pa_phase_e;

endpackage

// File: rtl/pa_phase_ctrl.sv
module pa_phase_ctrl
  import pair_add_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic cap_first,
  output logic pair_done
);

  pa_phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FIRST;
    end else if (take) begin
      phase_q <= (phase_q == PH_FIRST) ? PH_SECOND : PH_FIRST;
    end
  end

  always_comb begin
    cap_first = take && (phase_q == PH_FIRST);
    pair_done = take && (phase_q == PH_SECOND);
  end

endmodule

// File: rtl/pa_operand_reg.sv
module pa_operand_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/pa_sum_stage.sv
module pa_sum_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              valid_q,
  output logic [DATA_W-1:0] sum_q
);

  localparam int FULL_W = DATA_W + 1;

  logic [FULL_W-1:0] full_sum;
  logic [DATA_W-1:0] wrapped;

  always_comb begin
    full_sum = {1'b0, op_a} + {1'b0, op_b};
    wrapped  = full_sum[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      sum_q   <= '0;
    end else begin
      valid_q <= fire;
      if (fire) begin
        sum_q <= wrapped;
      end
    end
  end

endmodule

// File: rtl/pair_block_adder.sv
module pair_block_adder
  import pair_add_pkg::*;
#(
  parameter int DATA_W = PA_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_req,
  input  logic [DATA_W-1:0] smp_data,
  output logic              sum_valid,
  output logic [DATA_W-1:0] sum_data
);

  logic              cap_first;
  logic              pair_done;
  logic [DATA_W-1:0] first_op;

  pa_phase_ctrl u_phase (
    .clk       (clk),
    .rst       (rst),
    .take      (smp_req),
    .cap_first (cap_first),
    .pair_done (pair_done)
  );

  pa_operand_reg #(.DATA_W(DATA_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (cap_first),
    .d    (smp_data),
    .q    (first_op)
  );

  pa_sum_stage #(.DATA_W(DATA_W)) u_sum (
    .clk     (clk),
    .rst     (rst),
    .fire    (pair_done),
    .op_a    (first_op),
    .op_b    (smp_data),
    .valid_q (sum_valid),
    .sum_q   (sum_data)
  );

endmodule

// File: rtl/pair_block_adder_chk.sv
module pair_block_adder_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_req,
  input logic [DATA_W-1:0] smp_data,
  input logic              sum_valid,
  input logic [DATA_W-1:0] sum_data
);

  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
  end

  // R1: the cycle after a reset edge shows cleared outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    rst_q |-> (!sum_valid && sum_data == '0));

  // R4: valid pulses never last two cycles
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    sum_valid |=> !sum_valid);

  // R5: no accepted sample, no result in the next cycle
  a_r5_needs_sample: assert property (@(posedge clk) disable iff (rst)
    !smp_req |=> !sum_valid);

  // R7: output holds its value while not valid
  a_r7_hold_value: assert property (@(posedge clk) disable iff (rst || rst_q)
    !sum_valid |-> $stable(sum_data));

  // R7: output always defined after reset
  a_r7_no_unknown: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(sum_data));

endmodule

bind pair_block_adder pair_block_adder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_req   (smp_req),
  .smp_data  (smp_data),
  .sum_valid (sum_valid),
  .sum_data  (sum_data)
);

// File: tb/pair_block_adder_tb_top.sv
module pair_block_adder_tb_top;

  localparam int DW = 8;
  localparam int NVEC = 12;

  localparam logic [DW-1:0] VEC_IN [NVEC] = '{
    8'd45, 8'd8, 8'd23, 8'd19, 8'd12, 8'd34,
    8'd200, 8'd100, 8'd255, 8'd255, 8'd0, 8'd0
  };
  localparam logic [DW-1:0] VEC_EXP [NVEC] = '{
    8'd0, 8'd53, 8'd53, 8'd42, 8'd42, 8'd46,
    8'd46, 8'd44, 8'd44, 8'd254, 8'd254, 8'd0
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_req = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          sum_valid;
  logic [DW-1:0] sum_data;

  int n_checks = 0;
  int n_fails = 0;

  always #2 clk = ~clk;

  pair_block_adder #(.DATA_W(DW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .smp_req   (smp_req),
    .smp_data  (smp_data),
    .sum_valid (sum_valid),
    .sum_data  (sum_data)
  );

  task automatic step(input logic r, input logic v, input logic [DW-1:0] d);
    rst = r;
    smp_req = v;
    smp_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic exp_v, input logic [DW-1:0] exp_d);
    n_checks++;
    if (sum_valid !== exp_v || sum_data !== exp_d) begin
      n_fails++;
      $display("FAIL %s: valid=%b data=%0d expected valid=%b data=%0d",
               req, sum_valid, sum_data, exp_v, exp_d);
    end
  endtask

  initial begin
    #400000;
    n_fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    step(1'b1, 1'b0, 8'd0);
    step(1'b1, 1'b1, 8'd77);
    chk("R1 reset state", 1'b0, 8'd0);

    // table walk: R2 sums, R3 odd positions, R6 wrap
    for (int i = 0; i < NVEC; i++) begin
      step(1'b0, 1'b1, VEC_IN[i]);
      if (i % 2 == 0) chk("R3 odd position not valid", 1'b0, VEC_EXP[i]);
      else if (i >= 6) chk("R6 wrapped pair sum", 1'b1, VEC_EXP[i]);
      else chk("R2 pair sum", 1'b1, VEC_EXP[i]);
    end

    // R4: pulse drops with no new sample
    step(1'b0, 1'b0, 8'd0);
    chk("R4 single-cycle pulse", 1'b0, 8'd0);

    // R5 and R9: gap inside a pair with junk data
    step(1'b0, 1'b1, 8'd10);
    chk("R3 first of pair", 1'b0, 8'd0);
    step(1'b0, 1'b0, 8'd99);
    chk("R9 idle data ignored", 1'b0, 8'd0);
    step(1'b0, 1'b0, 8'd123);
    chk("R5 idle keeps phase", 1'b0, 8'd0);
    step(1'b0, 1'b1, 8'd7);
    chk("R5 sum across gap", 1'b1, 8'd17);
    step(1'b0, 1'b0, 8'd55);
    chk("R7 holds last sum", 1'b0, 8'd17);
    step(1'b0, 1'b0, 8'd1);
    chk("R7 holds last sum again", 1'b0, 8'd17);

    // R8: reset mid-pair
    step(1'b0, 1'b1, 8'd50);
    chk("R3 first before reset", 1'b0, 8'd17);
    step(1'b1, 1'b0, 8'd0);
    chk("R1 reset clears output", 1'b0, 8'd0);
    step(1'b0, 1'b1, 8'd3);
    chk("R8 new pair starts after reset", 1'b0, 8'd0);
    step(1'b0, 1'b1, 8'd4);
    chk("R8 stale operand dropped", 1'b1, 8'd7);

    // back-to-back pairs: R4 valid low between
    step(1'b0, 1'b1, 8'd128);
    chk("R4 low on next first sample", 1'b0, 8'd7);
    step(1'b0, 1'b1, 8'd128);
    chk("R6 128+128 wraps to 0", 1'b1, 8'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule